// File: doc/BRIEF.md
# SPI Master Serial Shift Engine

This block is the serial engine of a master-only SPI port that uses the Motorola frame format. It takes words from a transmit FIFO over a ready/valid handshake and shifts them out on MOSI, most significant bit first. At the same time it samples MISO, or its own MOSI when loopback is on, and offers each finished word to a receive FIFO. It also drives the serial clock and an active-low frame select.

A 16-bit control word sets the port's behaviour:

- bit 0 enables the port;
- bits 2:1 give the frame format;
- bits 9:5 give the word length minus one;
- bit 10 is clock polarity;
- bit 11 is clock phase;
- bit 12 is loopback;
- bit 14 is frame hold.

A half-period divider input sets the bit rate as a number of core clock cycles. The block samples the configuration when each word starts, so software may change it between words without corrupting a word in flight.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset with a zero control word, ss_n is high, sclk is low, and busy, tx_ready, rx_valid, underrun and overrun are all low.
- R2: The word length N is the value of bits 9:5 plus one, and field values 0, 1 and 2 select 4 bits. MOSI carries the low N bits of the popped word, most significant bit first.
- R3: rx_data holds the N received bits right-aligned, first-received bit highest, and bits N and above are zero.
- R4: Whenever busy is low, sclk equals control bit 10, so bit 10 = 0 means sclk idles low.
- R5: With control bit 11 = 0, input is sampled on the leading sclk edge and MOSI changes on the trailing edge. With bit 11 = 1, MOSI changes on the leading edge and input is sampled on the trailing edge.
- R6: Each sclk half period lasts half_div+1 core cycles, and busy is high for exactly 2*N*(half_div+1) cycles per word.
- R7: With control bit 12 = 1, the received word equals the transmitted word and MISO is ignored.
- R8: With control bit 14 = 0, ss_n is low only while busy. With bit 14 = 1, ss_n stays low for as long as the port is enabled with format 0.
- R9: When a word completes and tx_valid is low, underrun pulses for one cycle. An idle port that has not yet sent a word does not pulse underrun.
- R10: When a word completes while rx_ready is low, overrun pulses for one cycle and the word is dropped: no handshake takes place.
- R11: Clearing bit 0 mid-word drops busy and raises ss_n on the next cycle, returns sclk to idle, and the partial word is never presented on rx_valid.
- R12: When the frame-format field (bits 2:1) is not 0, no word is popped and tx_ready stays low.
- R13: tx_ready is high only with tx_valid. A waiting word is popped in the completion cycle of the previous word, so back-to-back words are separated by one core cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 16 | Control word (enable, format, size, polarity, phase, loopback, hold) |
| half_div | input | DIV_W | sclk half period minus one, in core cycles |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_data | input | 32 | Word at the head of the transmit FIFO |
| tx_ready | output | 1 | Pop strobe toward the transmit FIFO |
| rx_valid | output | 1 | A received word is offered (completion cycle) |
| rx_data | output | 32 | Received word, right-aligned |
| rx_ready | input | 1 | Receive FIFO can accept a word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low frame select |
| busy | output | 1 | A word is being shifted |
| underrun | output | 1 | One-cycle pulse: word finished with transmit FIFO empty |
| overrun | output | 1 | One-cycle pulse: finished word dropped, receive FIFO full |

## Verification
The bench builds the engine with DIV_W = 4. With that setting, divider values 0 to 2 keep every word to a few hundred cycles. This makes it cheap to run all 29 word lengths in all four polarity/phase combinations against a behavioural slave that shifts its own pattern on the opposite edge. Loopback, back-to-back words with and without frame hold, short-length field encodings, a full receive FIFO, an empty transmit FIFO, a non-zero format field and a mid-word disable are each driven as separate scenarios. The expected bit counts, masks and busy lengths are all computed arithmetically in the bench.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int MAX_BITS = 32;
  localparam int MIN_BITS = 4;
  localparam int CTRL_W   = 16;
  localparam int LEN_W    = $clog2(MAX_BITS) + 1;
  localparam int HALF_W   = LEN_W + 1;

  // control word field positions
  localparam int F_EN      = 0;
  localparam int F_FMT_LO  = 1;
  localparam int F_SIZE_LO = 5;
  localparam int F_CPOL    = 10;
  localparam int F_CPHA    = 11;
  localparam int F_LOOP    = 12;
  localparam int F_HOLD    = 14;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } eng_state_t;

  // word length from the length-minus-one field, clamped to the minimum
  function automatic logic [LEN_W-1:0] word_bits(input logic [4:0] field);
    if (field < 5'(MIN_BITS - 1)) return LEN_W'(MIN_BITS);
    return LEN_W'(field) + LEN_W'(1);
  endfunction

  // index of the last sclk half period of a word
  function automatic logic [HALF_W-1:0] last_half(input logic [LEN_W-1:0] nbits);
    return {nbits, 1'b0} - HALF_W'(1);
  endfunction
endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_eng_txshift.sv
module spi_eng_txshift
  import spi_eng_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                load,
  input  logic                cpha,
  input  logic                adv,
  input  logic [LEN_W-1:0]    nbits,
  input  logic [MAX_BITS-1:0] word,
  output logic                mosi
);
  logic [MAX_BITS-1:0] sh;
  logic [MAX_BITS-1:0] aligned;

  // move bit N-1 of the word to the top of the shifter
  assign aligned = word << (LEN_W'(MAX_BITS) - nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      mosi <= 1'b0;
    end else if (clr) begin
      sh   <= '0;
      mosi <= 1'b0;
    end else if (load) begin
      if (cpha) begin
        sh   <= aligned;
        mosi <= 1'b0;
      end else begin
        sh   <= aligned << 1;
        mosi <= aligned[MAX_BITS-1];
      end
    end else if (adv) begin
      mosi <= sh[MAX_BITS-1];
      sh   <= sh << 1;
    end
  end
endmodule

// File: rtl/spi_eng_rxshift.sv
module spi_eng_rxshift
  import spi_eng_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                shift,
  input  logic                din,
  output logic [MAX_BITS-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (clr)   word <= '0;
    else if (shift) word <= {word[MAX_BITS-2:0], din};
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CTRL_W-1:0]   ctrl_word,
  input  logic [DIV_W-1:0]    half_div,
  input  logic                tx_valid,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic                tx_ready,
  output logic                rx_valid,
  output logic [MAX_BITS-1:0] rx_data,
  input  logic                rx_ready,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic                ss_n,
  output logic                busy,
  output logic                underrun,
  output logic                overrun
);
  // live control fields
  logic             c_en, c_motorola, c_cpol, c_cpha, c_loop, c_hold;
  logic [LEN_W-1:0] c_bits;
  logic             ctrl_unused;

  assign c_en       = ctrl_word[F_EN];
  assign c_motorola = (ctrl_word[F_FMT_LO +: 2] == 2'b00);
  assign c_bits     = word_bits(ctrl_word[F_SIZE_LO +: 5]);
  assign c_cpol     = ctrl_word[F_CPOL];
  assign c_cpha     = ctrl_word[F_CPHA];
  assign c_loop     = ctrl_word[F_LOOP];
  assign c_hold     = ctrl_word[F_HOLD];
  assign ctrl_unused = ^{ctrl_word[15], ctrl_word[13], ctrl_word[4:3]};

  // per-word configuration captured at word start
  logic [LEN_W-1:0] q_bits;
  logic             q_cpol, q_cpha, q_loop;
  logic [DIV_W-1:0] q_div;

  eng_state_t        state;
  logic              lvl;
  logic [HALF_W-1:0] hcnt;

  // named internal events
  logic active, start, tick, lead_evt, trail_evt, drive_evt, sample_evt, word_end;
  logic shifting, rx_bit;

  assign active     = c_en & c_motorola;
  assign shifting   = (state == ST_SHIFT);
  assign start      = active & tx_valid & ~shifting;
  assign lead_evt   = tick & ~hcnt[0];
  assign trail_evt  = tick &  hcnt[0];
  assign drive_evt  = shifting & (q_cpha ? lead_evt : trail_evt);
  assign sample_evt = shifting & (q_cpha ? trail_evt : lead_evt);
  assign word_end   = shifting & trail_evt & (hcnt == last_half(q_bits));
  assign rx_bit     = q_loop ? mosi : miso;

  spi_eng_tick #(.DIV_W(DIV_W)) tick_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (shifting),
    .div  (q_div),
    .tick (tick)
  );

  spi_eng_txshift tx_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~active),
    .load (start),
    .cpha (c_cpha),
    .adv  (drive_evt),
    .nbits(c_bits),
    .word (tx_data),
    .mosi (mosi)
  );

  spi_eng_rxshift rx_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .shift(sample_evt),
    .din  (rx_bit),
    .word (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lvl    <= 1'b0;
      hcnt   <= '0;
      q_bits <= LEN_W'(MIN_BITS);
      q_cpol <= 1'b0;
      q_cpha <= 1'b0;
      q_loop <= 1'b0;
      q_div  <= '0;
    end else if (!active) begin
      state <= ST_IDLE;
      lvl   <= 1'b0;
      hcnt  <= '0;
    end else if (start) begin
      state  <= ST_SHIFT;
      lvl    <= 1'b0;
      hcnt   <= '0;
      q_bits <= c_bits;
      q_cpol <= c_cpol;
      q_cpha <= c_cpha;
      q_loop <= c_loop;
      q_div  <= half_div;
    end else if (shifting && tick) begin
      lvl  <= ~lvl;
      hcnt <= hcnt + 1'b1;
      if (word_end) state <= ST_DONE;
    end else if (state == ST_DONE) begin
      state <= ST_IDLE;
    end
  end

  assign tx_ready = start;
  assign busy     = shifting;
  assign sclk     = lvl ^ (shifting ? q_cpol : c_cpol);
  assign ss_n     = ~(shifting | (active & c_hold));
  assign rx_valid = (state == ST_DONE);
  assign underrun = (state == ST_DONE) & active & ~tx_valid;
  assign overrun  = (state == ST_DONE) & ~rx_ready;
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_bit,
  input logic [1:0] fmt_bits,
  input logic       cpol_bit,
  input logic       hold_bit,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       sclk,
  input logic       ss_n,
  input logic       busy,
  input logic       underrun,
  input logic       overrun,
  input logic       tick
);
  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol_bit));

  // R8
  select_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hold_bit) |-> ss_n);

  // R13
  pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_valid);

  // R12
  format_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_bits != 2'b00) |-> !tx_ready);

  // R9
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!tx_valid && !busy));

  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> (rx_valid && !rx_ready));

  // R11
  disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_bit |=> !busy);

  // R6
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && en_bit && fmt_bits == 2'b00) |=> $stable(sclk));
endmodule

bind spi_shift_engine spi_shift_engine_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_bit  (ctrl_word[0]),
  .fmt_bits(ctrl_word[2:1]),
  .cpol_bit(ctrl_word[10]),
  .hold_bit(ctrl_word[14]),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .rx_valid(rx_valid),
  .rx_ready(rx_ready),
  .sclk    (sclk),
  .ss_n    (ss_n),
  .busy    (busy),
  .underrun(underrun),
  .overrun (overrun),
  .tick    (tick)
);

// File: tb/spi_shift_engine_tb_top.sv
`timescale 1ns/1ps
module spi_shift_engine_tb_top;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   ctrl_word = '0;
  logic [DW-1:0] half_div = '0;
  logic          tx_valid = 1'b0;
  logic [31:0]   tx_data = '0;
  logic          tx_ready;
  logic          rx_valid;
  logic [31:0]   rx_data;
  logic          rx_ready = 1'b1;
  logic          sclk, mosi, ss_n, busy, underrun, overrun;
  logic          miso_r = 1'b0;

  always #5 clk = ~clk;

  spi_shift_engine #(.DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .half_div(half_div),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .sclk(sclk), .mosi(mosi), .miso(miso_r), .ss_n(ss_n),
    .busy(busy), .underrun(underrun), .overrun(overrun)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // port-level monitor
  int pops = 0, pushes = 0, rx_seen = 0, und_n = 0, ovr_n = 0, ss_hi = 0, cyc = 0;
  bit ss_mon = 0;
  logic [31:0] rxlog [4];
  always @(posedge clk) begin
    cyc++;
    if (tx_valid && tx_ready) pops++;
    if (rx_valid) rx_seen++;
    if (rx_valid && rx_ready) begin
      rxlog[pushes % 4] = rx_data;
      pushes++;
    end
    if (underrun) und_n++;
    if (overrun) ovr_n++;
    if (ss_mon && ss_n) ss_hi++;
  end

  // behavioural slave: shifts its pattern on the drive edge, captures MOSI on the sample edge
  bit          s_cpol = 0, s_cpha = 0;
  int          s_idx = -1, s_n = 4;
  logic [31:0] s_word = '0;
  logic [31:0] cap = '0;
  always @(sclk) begin
    if (sclk !== s_cpol) begin
      if (!s_cpha) cap = {cap[30:0], mosi};
      else begin
        if (s_idx >= 0) miso_r = s_word[s_idx];
        s_idx--;
      end
    end else begin
      if (!s_cpha) begin
        if (s_idx >= 0) miso_r = s_word[s_idx];
        s_idx--;
      end else cap = {cap[30:0], mosi};
    end
  end

  function automatic int len_of(input logic [4:0] f);
    return (f <= 5'd2) ? 4 : int'(f) + 1;
  endfunction
  function automatic logic [31:0] mask_of(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction
  function automatic logic [15:0] mk_ctrl(input int n, input bit cpol, input bit cpha,
                                          input bit lp, input bit hold);
    logic [15:0] c;
    c = 16'h0001;
    c[9:5] = 5'(n - 1);
    c[10] = cpol; c[11] = cpha; c[12] = lp; c[14] = hold;
    return c;
  endfunction

  // one word with full checking
  task automatic run_word(input logic [15:0] c, input logic [31:0] w, input logic [31:0] sw,
                          input int dv, input bit rr);
    int n, bcnt, pushes0, und0;
    bit ss_ok;
    logic [31:0] exp_rx;
    n = len_of(c[9:5]);
    @(negedge clk);
    ctrl_word = c; half_div = DW'(dv); rx_ready = rr;
    @(negedge clk);
    s_cpol = c[10]; s_cpha = c[11]; s_n = n; s_word = sw; cap = '0;
    if (!c[11]) begin miso_r = sw[n-1]; s_idx = n - 2; end
    else s_idx = n - 1;
    chk(sclk == c[10], "R4 idle sclk level", {31'd0, sclk}, {31'd0, c[10]});
    pushes0 = pushes; und0 = und_n;
    tx_valid = 1'b1; tx_data = w;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    bcnt = 0; ss_ok = 1;
    while (busy && bcnt < 4000) begin
      bcnt++;
      if (ss_n) ss_ok = 0;
      @(negedge clk);
    end
    chk(bcnt == 2 * n * (dv + 1), "R6 busy length", bcnt, 2 * n * (dv + 1));
    chk(ss_ok, "R8 select low while busy", {31'd0, ss_ok}, 32'd1);
    chk(ss_n == !c[14], "R8 select after word", {31'd0, ss_n}, {31'd0, !c[14]});
    chk(sclk == c[10], "R4 sclk back to idle", {31'd0, sclk}, {31'd0, c[10]});
    exp_rx = (c[12] ? w : sw) & mask_of(n);
    chk(rx_valid == 1'b1, "R3 rx_valid on completion", {31'd0, rx_valid}, 32'd1);
    chk(rx_data == exp_rx, c[12] ? "R7 loopback word" : "R3 R5 received word", rx_data, exp_rx);
    chk(cap == (w & mask_of(n)), "R2 R5 MOSI bits msb first", cap, w & mask_of(n));
    chk(underrun == 1'b1, "R9 underrun at empty boundary", {31'd0, underrun}, 32'd1);
    chk(overrun == !rr, "R10 overrun flag", {31'd0, overrun}, {31'd0, !rr});
    @(negedge clk);
    chk(pushes - pushes0 == (rr ? 1 : 0), rr ? "R3 word pushed" : "R10 word dropped",
        pushes - pushes0, rr ? 1 : 0);
    chk(und_n - und0 == 1, "R9 single underrun pulse", und_n - und0, 1);
    rx_ready = 1'b1;
  endtask

  // two words back to back through loopback
  task automatic run_pair(input bit hold, input logic [31:0] w1, input logic [31:0] w2);
    int p0, u0, guard;
    logic [15:0] c;
    c = mk_ctrl(12, 0, 1, 1, hold);
    @(negedge clk);
    ctrl_word = c; half_div = DW'(1);
    @(negedge clk);
    p0 = pushes; u0 = und_n; ss_hi = 0;
    tx_valid = 1'b1; tx_data = w1;
    @(posedge clk);
    @(negedge clk);
    ss_mon = 1; tx_data = w2;
    guard = 0;
    while (!tx_ready && guard < 4000) begin guard++; @(negedge clk); end
    chk(busy == 1'b0 && rx_valid == 1'b1, "R13 second pop in completion cycle",
        {30'd0, busy, rx_valid}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(busy == 1'b1, "R13 next word starts after one cycle", {31'd0, busy}, 32'd1);
    guard = 0;
    while (busy && guard < 4000) begin guard++; @(negedge clk); end
    ss_mon = 0;
    @(negedge clk);
    chk(ss_hi == (hold ? 0 : 1), hold ? "R8 hold keeps select low" : "R8 select gap without hold",
        ss_hi, hold ? 0 : 1);
    chk(pushes - p0 == 2, "R13 two words received", pushes - p0, 2);
    chk(rxlog[p0 % 4] == (w1 & 32'hFFF), "R13 first word", rxlog[p0 % 4], w1 & 32'hFFF);
    chk(rxlog[(p0 + 1) % 4] == (w2 & 32'hFFF), "R13 second word", rxlog[(p0 + 1) % 4], w2 & 32'hFFF);
    chk(und_n - u0 == 1, "R9 underrun only after last word", und_n - u0, 1);
  endtask

  initial begin
    int p0, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ss_n == 1'b1, "R1 ss_n reset", {31'd0, ss_n}, 32'd1);
    chk(sclk == 1'b0, "R1 sclk reset", {31'd0, sclk}, 32'd0);
    chk({busy, tx_ready, rx_valid, underrun, overrun} == 5'b0, "R1 outputs reset",
        {27'd0, busy, tx_ready, rx_valid, underrun, overrun}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: enabled idle port with nothing queued stays quiet
    ctrl_word = mk_ctrl(8, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    chk(und_n == 0, "R9 no underrun before first word", und_n, 0);

    // sweep all lengths in all four clock modes
    for (int m = 0; m < 4; m++) begin
      for (int n = 4; n <= 32; n++) begin
        logic [31:0] w, sw;
        w  = 32'h9E37_79B9 * 32'(n) + 32'h0123_4567 * 32'(m + 1);
        sw = {w[14:0], w[31:15]} ^ 32'hA5C3_5A3C;
        run_word(mk_ctrl(n, m[0], m[1], 0, 0), w, sw, n % 3, 1'b1);
      end
    end
    // R2 short-length field encodings all mean 4 bits
    for (int f = 0; f < 3; f++) begin
      logic [15:0] c;
      c = mk_ctrl(4, 0, 0, 0, 0);
      c[9:5] = 5'(f);
      run_word(c, 32'hFFFF_FFF6, 32'h0000_0009, 0, 1'b1);
    end
    // R7 loopback in every mode, MISO carrying the opposite pattern
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 4; k++) begin
        int n;
        logic [31:0] w;
        n = 4 + 9 * k;
        if (n > 32) n = 32;
        w = 32'hC0DE_1234 ^ (32'h1111_1111 * 32'(k + m));
        run_word(mk_ctrl(n, m[0], m[1], 1, m[0]), w, ~w, m % 3, 1'b1);
      end
    end
    // R10 receive side full
    run_word(mk_ctrl(16, 1, 0, 0, 0), 32'h0000_BEEF, 32'h0000_1357, 1, 1'b0);
    run_word(mk_ctrl(9, 0, 1, 0, 1), 32'h0000_01AA, 32'h0000_0155, 2, 1'b0);
    // R13 and R8 back-to-back
    run_pair(1'b1, 32'h0000_0A5C, 32'h0000_0F0F);
    run_pair(1'b0, 32'h0000_0333, 32'h0000_0CCC);

    // R11 disable mid-word
    @(negedge clk);
    ctrl_word = mk_ctrl(16, 1, 0, 0, 1); half_div = DW'(2);
    @(negedge clk);
    r0 = rx_seen;
    tx_valid = 1'b1; tx_data = 32'h0000_ABCD;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b1 && ss_n == 1'b0, "R11 word in flight", {30'd0, busy, ss_n}, 32'd2);
    ctrl_word[0] = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy dropped", {31'd0, busy}, 32'd0);
    chk(ss_n == 1'b1, "R11 select released", {31'd0, ss_n}, 32'd1);
    chk(sclk == 1'b1, "R11 sclk idle", {31'd0, sclk}, 32'd1);
    repeat (120) @(negedge clk);
    chk(rx_seen == r0, "R11 partial word discarded", rx_seen - r0, 0);

    // R12 non-zero frame format blocks popping
    ctrl_word = mk_ctrl(8, 0, 0, 0, 1);
    ctrl_word[2:1] = 2'b01;
    p0 = pops;
    tx_valid = 1'b1; tx_data = 32'h0000_0055;
    repeat (40) @(negedge clk);
    chk(pops == p0, "R12 no pop with other format", pops - p0, 0);
    chk(ss_n == 1'b1 && busy == 1'b0, "R12 port stays idle", {30'd0, ss_n, busy}, 32'd2);
    tx_valid = 1'b0;
    @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule